// File: doc/BRIEF.md
# Disk Data Formatter with Servo Split

This block sits between a byte-wide sector buffer and the 8-bit NRZ byte bus of a read/write channel. It carries one sector per start command. A media byte strobe (`byte_en`, one clock cycle wide) sets a fixed byte rate that the block cannot slow down. On a write, each data segment begins with a programmable run of pad bytes and a sync mark. The user bytes taken from the buffer follow, and then the check bytes that an external ECC unit supplies. On a read, the block hunts for the sync mark. It then passes the user bytes toward the buffer and the check bytes toward the ECC unit.

A servo gate input marks the servo wedges. When the gate is high at a strobe, the field is suspended: both gates drop, nothing is driven and nothing is consumed. At the first strobe after the wedge with the gate low, a new segment starts (pad and sync on a write, a fresh sync hunt on a read). The data continues at the exact byte that follows the last one moved. A sector may be split any number of times.

The controller has six states. S_IDLE goes to S_PRE (write) or S_HUNT (read) on `start`. S_PRE goes to S_USER after the sync byte. S_HUNT goes to S_USER when the sync byte is seen. S_USER acts as S_CHECK once all user bytes have moved. S_CHECK goes to S_IDLE with `done` on the strobe after the last check byte. Any field state goes to S_WEDGE at a strobe with the servo gate high. S_WEDGE goes back to S_PRE or S_HUNT at a strobe with the servo gate low. S_USER goes to S_IDLE on an underrun or an overrun.

Top module: `disk_formatter`

## Requirements
- R1: After reset, write_gate, read_gate, done, user_valid, chk_valid, err_underrun and err_overrun are all 0.
- R2: A write sector with no servo wedge appears on nrz_out, with write_gate high, as pre_len bytes of 0x00, one byte 0xA1, sect_len buffer bytes in buffer order, and then ecc_len ECC bytes in order. write_gate and read_gate are never high together.
- R3: On a read (dir_write=0), bytes before the first 0xA1 are discarded. The next sect_len bytes are presented one by one on user_data with user_valid, and the next ecc_len bytes on chk_data with chk_valid. A 0xA1 inside the data is passed through as data.
- R4: At any strobe with servo_gate high, write_gate and read_gate are low from that strobe until the next strobe, and no buffer or ECC byte is taken.
- R5: After a wedge, a write restarts with pre_len 0x00 bytes and 0xA1, then continues with the next unsent byte. A read re-hunts for 0xA1, ignoring any 0xA1 sampled during the wedge, and then continues with the next byte. More than one wedge per sector is handled.
- R6: At every strobe in a data phase outside a wedge, exactly one byte is transferred. A wedge-free write sector finishes after exactly pre_len+sect_len+ecc_len+2 strobes.
- R7: If buf_valid is low at a strobe where a user byte is due on a write, err_underrun pulses, write_gate goes low, the sector ends and done is not raised.
- R8: If user_ready is low at a strobe where a read user byte is accepted, err_overrun pulses, read_gate goes low, the sector ends and done is not raised.
- R9: done is a single-cycle pulse following the strobe after the last check byte, with both gates low from then on.
- R10: write_gate and read_gate change only in the cycle following a byte strobe.
- R11: With pre_len = 0, the first byte of each write segment is the sync byte 0xA1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins a sector; lengths and direction are latched (S_IDLE only) |
| dir_write | input | 1 | 1 = write sector, 0 = read sector |
| sect_len | input | LEN_W | User bytes per sector (at least 1) |
| ecc_len | input | ECC_W | Check bytes per sector (at least 1) |
| pre_len | input | PRE_W | Pad bytes before each sync byte |
| byte_en | input | 1 | Media byte strobe, one cycle wide |
| servo_gate | input | 1 | High inside a servo wedge, sampled at strobes |
| buf_data | input | 8 | Buffer byte for writing |
| buf_valid | input | 1 | buf_data is available |
| buf_take | output | 1 | Buffer byte consumed this cycle |
| ecc_data | input | 8 | Next check byte from the ECC unit |
| ecc_take | output | 1 | Check byte consumed this cycle |
| nrz_out | output | 8 | Byte driven to the channel |
| write_gate | output | 1 | Write field active |
| nrz_in | input | 8 | Byte from the channel |
| read_gate | output | 1 | Read field active |
| user_data | output | 8 | User byte read from media |
| user_valid | output | 1 | user_data valid pulse |
| user_ready | input | 1 | Buffer side can accept a user byte |
| chk_data | output | 8 | Check byte read from media |
| chk_valid | output | 1 | chk_data valid pulse |
| done | output | 1 | Sector complete pulse |
| err_underrun | output | 1 | Write underrun abort pulse |
| err_overrun | output | 1 | Read overrun abort pulse |

## Verification
The assertions assume that `byte_en` is a single-cycle strobe with at least one idle cycle between strobes. They also assume that `start` arrives only while the block is idle, and that `sect_len` and `ecc_len` are at least 1. The stimulus meets these conditions: it spaces strobes four clocks apart and issues `start` only after the previous sector's done or error pulse. Servo gate, channel input and buffer handshakes are changed only between strobes, away from the sampling edge. Wedges are placed in the data phase, in the check phase and in the middle of a preamble.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_HUNT,
        S_USER,
        S_CHECK,
        S_WEDGE
    } fmt_state_e;

    localparam logic [7:0] FMT_PAD  = 8'h00;
    localparam logic [7:0] FMT_SYNC = 8'hA1;
endpackage

// File: rtl/fmt_count.sv
module fmt_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] limit_in,
    input  logic         clr,
    input  logic         inc,
    output logic         full
);
    logic [W-1:0] lim_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            lim_q <= limit_in;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign full = (cnt_q == lim_q);

    // The controller must never advance a counter that has reached its limit.
    assert_inc_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !full);
endmodule

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
    import fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_en,
    input  logic       start,
    input  logic       dir_write,
    input  logic       servo_gate,
    input  logic [7:0] buf_data,
    input  logic       buf_valid,
    input  logic [7:0] ecc_data,
    input  logic [7:0] nrz_in,
    input  logic       user_ready,
    input  logic       pre_full,
    input  logic       user_full,
    input  logic       chk_full,
    output logic       cfg_load,
    output logic       pre_clr,
    output logic       pre_inc,
    output logic       user_inc,
    output logic       chk_inc,
    output logic       buf_take,
    output logic       ecc_take,
    output logic [7:0] nrz_out,
    output logic       write_gate,
    output logic       read_gate,
    output logic [7:0] user_data,
    output logic       user_valid,
    output logic [7:0] chk_data,
    output logic       chk_valid,
    output logic       done,
    output logic       err_underrun,
    output logic       err_overrun
);
    fmt_state_e state_q, state_d, eff;
    logic       dir_q, dir_d;

    logic [7:0] nrz_d, ud_d, cd_d;
    logic       wg_d, rg_d, uv_d, cv_d, done_d, eu_d, eo_d;

    // Effective state: a wedge resumes as a new segment, and a finished
    // user phase acts as the check phase.
    always_comb begin
        eff = state_q;
        if (state_q == S_WEDGE) begin
            eff = dir_q ? S_PRE : S_HUNT;
        end else if (state_q == S_USER && user_full) begin
            eff = S_CHECK;
        end
    end

    always_comb begin
        state_d  = state_q;
        dir_d    = dir_q;
        cfg_load = 1'b0;
        pre_clr  = 1'b0;
        pre_inc  = 1'b0;
        user_inc = 1'b0;
        chk_inc  = 1'b0;
        buf_take = 1'b0;
        ecc_take = 1'b0;
        nrz_d    = nrz_out;
        wg_d     = write_gate;
        rg_d     = read_gate;
        ud_d     = user_data;
        cd_d     = chk_data;
        uv_d     = 1'b0;
        cv_d     = 1'b0;
        done_d   = 1'b0;
        eu_d     = 1'b0;
        eo_d     = 1'b0;

        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    cfg_load = 1'b1;
                    dir_d    = dir_write;
                    state_d  = dir_write ? S_PRE : S_HUNT;
                end
            end
            default: begin
                if (byte_en) begin
                    if (eff == S_CHECK && chk_full) begin
                        done_d  = 1'b1;
                        wg_d    = 1'b0;
                        rg_d    = 1'b0;
                        nrz_d   = FMT_PAD;
                        state_d = S_IDLE;
                    end else if (servo_gate) begin
                        wg_d    = 1'b0;
                        rg_d    = 1'b0;
                        nrz_d   = FMT_PAD;
                        pre_clr = 1'b1;
                        state_d = S_WEDGE;
                    end else begin
                        unique case (eff)
                            S_PRE: begin
                                wg_d = 1'b1;
                                if (!pre_full) begin
                                    nrz_d   = FMT_PAD;
                                    pre_inc = 1'b1;
                                    state_d = S_PRE;
                                end else begin
                                    nrz_d   = FMT_SYNC;
                                    state_d = S_USER;
                                end
                            end
                            S_HUNT: begin
                                rg_d    = 1'b1;
                                state_d = (nrz_in == FMT_SYNC) ? S_USER : S_HUNT;
                            end
                            S_USER: begin
                                if (dir_q) begin
                                    if (buf_valid) begin
                                        buf_take = 1'b1;
                                        user_inc = 1'b1;
                                        nrz_d    = buf_data;
                                        wg_d     = 1'b1;
                                    end else begin
                                        eu_d    = 1'b1;
                                        wg_d    = 1'b0;
                                        nrz_d   = FMT_PAD;
                                        state_d = S_IDLE;
                                    end
                                end else begin
                                    if (user_ready) begin
                                        user_inc = 1'b1;
                                        ud_d     = nrz_in;
                                        uv_d     = 1'b1;
                                        rg_d     = 1'b1;
                                    end else begin
                                        eo_d    = 1'b1;
                                        rg_d    = 1'b0;
                                        state_d = S_IDLE;
                                    end
                                end
                            end
                            S_CHECK: begin
                                chk_inc = 1'b1;
                                state_d = S_CHECK;
                                if (dir_q) begin
                                    ecc_take = 1'b1;
                                    nrz_d    = ecc_data;
                                    wg_d     = 1'b1;
                                end else begin
                                    cd_d = nrz_in;
                                    cv_d = 1'b1;
                                    rg_d = 1'b1;
                                end
                            end
                            default: begin
                                state_d = S_IDLE;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nrz_out      <= FMT_PAD;
            write_gate   <= 1'b0;
            read_gate    <= 1'b0;
            user_data    <= '0;
            user_valid   <= 1'b0;
            chk_data     <= '0;
            chk_valid    <= 1'b0;
            done         <= 1'b0;
            err_underrun <= 1'b0;
            err_overrun  <= 1'b0;
        end else begin
            nrz_out      <= nrz_d;
            write_gate   <= wg_d;
            read_gate    <= rg_d;
            user_data    <= ud_d;
            user_valid   <= uv_d;
            chk_data     <= cd_d;
            chk_valid    <= cv_d;
            done         <= done_d;
            err_underrun <= eu_d;
            err_overrun  <= eo_d;
        end
    end

    assert_gates_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(write_gate && read_gate));

    assert_wedge_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_en && servo_gate |=> !write_gate && !read_gate);

    assert_take_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_take || ecc_take) |-> byte_en && !servo_gate);

    assert_underrun_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |-> !write_gate && !done);

    assert_overrun_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> !read_gate && !done);

    assert_done_gates_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !write_gate && !read_gate);

    assert_gate_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_en |=> $stable(write_gate) && $stable(read_gate));
endmodule

// File: rtl/disk_formatter.sv
module disk_formatter #(
    parameter int LEN_W = 12,
    parameter int ECC_W = 6,
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_write,
    input  logic [LEN_W-1:0] sect_len,
    input  logic [ECC_W-1:0] ecc_len,
    input  logic [PRE_W-1:0] pre_len,
    input  logic             byte_en,
    input  logic             servo_gate,
    input  logic [7:0]       buf_data,
    input  logic             buf_valid,
    output logic             buf_take,
    input  logic [7:0]       ecc_data,
    output logic             ecc_take,
    output logic [7:0]       nrz_out,
    output logic             write_gate,
    input  logic [7:0]       nrz_in,
    output logic             read_gate,
    output logic [7:0]       user_data,
    output logic             user_valid,
    input  logic             user_ready,
    output logic [7:0]       chk_data,
    output logic             chk_valid,
    output logic             done,
    output logic             err_underrun,
    output logic             err_overrun
);
    logic cfg_load, pre_clr, pre_inc, user_inc, chk_inc;
    logic pre_full, user_full, chk_full;

    fmt_count #(.W(PRE_W)) u_pre_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .limit_in (pre_len),
        .clr      (pre_clr),
        .inc      (pre_inc),
        .full     (pre_full)
    );

    fmt_count #(.W(LEN_W)) u_user_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .limit_in (sect_len),
        .clr      (1'b0),
        .inc      (user_inc),
        .full     (user_full)
    );

    fmt_count #(.W(ECC_W)) u_chk_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .limit_in (ecc_len),
        .clr      (1'b0),
        .inc      (chk_inc),
        .full     (chk_full)
    );

    fmt_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_en      (byte_en),
        .start        (start),
        .dir_write    (dir_write),
        .servo_gate   (servo_gate),
        .buf_data     (buf_data),
        .buf_valid    (buf_valid),
        .ecc_data     (ecc_data),
        .nrz_in       (nrz_in),
        .user_ready   (user_ready),
        .pre_full     (pre_full),
        .user_full    (user_full),
        .chk_full     (chk_full),
        .cfg_load     (cfg_load),
        .pre_clr      (pre_clr),
        .pre_inc      (pre_inc),
        .user_inc     (user_inc),
        .chk_inc      (chk_inc),
        .buf_take     (buf_take),
        .ecc_take     (ecc_take),
        .nrz_out      (nrz_out),
        .write_gate   (write_gate),
        .read_gate    (read_gate),
        .user_data    (user_data),
        .user_valid   (user_valid),
        .chk_data     (chk_data),
        .chk_valid    (chk_valid),
        .done         (done),
        .err_underrun (err_underrun),
        .err_overrun  (err_overrun)
    );
endmodule

// File: tb/disk_formatter_tb.sv
module disk_formatter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 12;
    localparam int ECC_W = 6;
    localparam int PRE_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             dir_write = 1'b0;
    logic [LEN_W-1:0] sect_len = '0;
    logic [ECC_W-1:0] ecc_len = '0;
    logic [PRE_W-1:0] pre_len = '0;
    logic             byte_en = 1'b0;
    logic             servo_gate = 1'b0;
    logic [7:0]       buf_data;
    logic             buf_valid;
    logic             buf_take;
    logic [7:0]       ecc_data;
    logic             ecc_take;
    logic [7:0]       nrz_out;
    logic             write_gate;
    logic [7:0]       nrz_in = 8'h00;
    logic             read_gate;
    logic [7:0]       user_data;
    logic             user_valid;
    logic             user_ready = 1'b1;
    logic [7:0]       chk_data;
    logic             chk_valid;
    logic             done;
    logic             err_underrun;
    logic             err_overrun;

    always #(CLK_PERIOD/2) clk = ~clk;

    disk_formatter #(.LEN_W(LEN_W), .ECC_W(ECC_W), .PRE_W(PRE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .sect_len(sect_len), .ecc_len(ecc_len), .pre_len(pre_len),
        .byte_en(byte_en), .servo_gate(servo_gate),
        .buf_data(buf_data), .buf_valid(buf_valid), .buf_take(buf_take),
        .ecc_data(ecc_data), .ecc_take(ecc_take),
        .nrz_out(nrz_out), .write_gate(write_gate),
        .nrz_in(nrz_in), .read_gate(read_gate),
        .user_data(user_data), .user_valid(user_valid), .user_ready(user_ready),
        .chk_data(chk_data), .chk_valid(chk_valid),
        .done(done), .err_underrun(err_underrun), .err_overrun(err_overrun)
    );

    // Buffer and ECC source models
    logic [7:0] ub [0:31];
    logic [7:0] eb [0:15];
    logic [5:0] bidx = '0;
    logic [4:0] eidx = '0;
    logic       idx_clr = 1'b0;
    int         stall_idx = -1;

    assign buf_data  = ub[bidx[4:0]];
    assign ecc_data  = eb[eidx[3:0]];
    assign buf_valid = (int'(bidx) != stall_idx);

    always @(posedge clk) begin
        if (idx_clr) begin
            bidx <= '0;
            eidx <= '0;
        end else begin
            if (buf_take) bidx <= bidx + 6'd1;
            if (ecc_take) eidx <= eidx + 5'd1;
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    function automatic void check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endfunction

    // Scoreboard queues
    logic [7:0] exp_w [$];
    logic [7:0] exp_u [$];
    logic [7:0] exp_c [$];
    int  cur_pre = 0;
    int  seg_pos = 0;
    int  seg_idx = 0;
    bit  prev_wg = 1'b0;
    bit  pwg_any = 1'b0;
    bit  prg_any = 1'b0;
    int  done_cnt = 0;
    int  eu_cnt = 0;
    int  eo_cnt = 0;
    logic strobed = 1'b0;
    logic sv_at = 1'b0;
    bit  sched [0:199];

    always @(posedge clk) begin
        strobed <= byte_en;
        sv_at   <= byte_en & servo_gate;
    end

    // Monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (write_gate != pwg_any || read_gate != prg_any) begin
                check(strobed == 1'b1, "R10 gate change off strobe", int'(strobed), 1);
            end
            pwg_any = write_gate;
            prg_any = read_gate;
            if (strobed) begin
                if (sv_at) begin
                    check(!write_gate && !read_gate, "R4 gates in wedge",
                          int'({write_gate, read_gate}), 0);
                end
                if (write_gate) begin
                    logic [7:0] e;
                    bit have;
                    string tag;
                    if (!prev_wg) begin
                        seg_pos = 0;
                        seg_idx++;
                    end
                    have = 1'b1;
                    if (seg_pos < cur_pre) e = 8'h00;
                    else if (seg_pos == cur_pre) e = 8'hA1;
                    else if (exp_w.size() > 0) e = exp_w.pop_front();
                    else begin e = 8'h00; have = 1'b0; end
                    if (cur_pre == 0 && seg_pos == 0) tag = "R11 sync first";
                    else if (seg_idx > 1) tag = "R5 resumed byte";
                    else tag = "R2 write byte";
                    check(have && nrz_out == e, tag, int'(nrz_out), int'(e));
                    seg_pos++;
                end
                prev_wg = write_gate;
            end
            if (user_valid) begin
                logic [7:0] e;
                e = (exp_u.size() > 0) ? exp_u.pop_front() : 8'hFF;
                check(user_data == e, "R3 user byte", int'(user_data), int'(e));
            end
            if (chk_valid) begin
                logic [7:0] e;
                e = (exp_c.size() > 0) ? exp_c.pop_front() : 8'hFF;
                check(chk_data == e, "R3 check byte", int'(chk_data), int'(e));
            end
            if (done) begin
                done_cnt++;
                check(!write_gate && !read_gate, "R9 gates at done",
                      int'({write_gate, read_gate}), 0);
            end
            if (err_underrun) eu_cnt++;
            if (err_overrun) eo_cnt++;
        end
    end

    task automatic strobe(input bit sv, input logic [7:0] din);
        @(negedge clk);
        byte_en    = 1'b1;
        servo_gate = sv;
        nrz_in     = din;
        @(negedge clk);
        byte_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_start(input bit wr, input int sect, input int ecc, input int pre);
        @(negedge clk);
        idx_clr = 1'b1;
        @(negedge clk);
        idx_clr   = 1'b0;
        dir_write = wr;
        sect_len  = LEN_W'(sect);
        ecc_len   = ECC_W'(ecc);
        pre_len   = PRE_W'(pre);
        cur_pre   = pre;
        seg_idx   = 0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic clear_sched();
        for (int i = 0; i < 200; i++) sched[i] = 1'b0;
    endtask

    // Write sector; returns the number of strobes used
    task automatic write_sector(input int sect, input int ecc, input int pre,
                                input int stall, output int n_strobe);
        int d0, e0;
        bit fin;
        for (int i = 0; i < sect; i++) ub[i] = 8'h40 + 8'(i * 13);
        for (int i = 0; i < ecc; i++) eb[i] = 8'hE0 + 8'(i);
        exp_w.delete();
        for (int i = 0; i < sect; i++) begin
            if (stall < 0 || i < stall) exp_w.push_back(ub[i]);
        end
        if (stall < 0) for (int i = 0; i < ecc; i++) exp_w.push_back(eb[i]);
        stall_idx = stall;
        d0 = done_cnt;
        e0 = eu_cnt;
        do_start(1'b1, sect, ecc, pre);
        fin = 1'b0;
        n_strobe = 0;
        for (int i = 0; i < 200 && !fin; i++) begin
            strobe(sched[i], 8'h00);
            n_strobe++;
            fin = (done_cnt != d0) || (eu_cnt != e0);
        end
        stall_idx = -1;
    endtask

    task automatic read_sector(input int sect, input int ecc, input int split_a,
                               input int split_b, input int ovr);
        logic [7:0] d [0:31];
        int n;
        n = sect + ecc;
        for (int k = 0; k < n; k++) d[k] = 8'h11 + 8'(k * 37);
        d[2] = 8'hA1;
        exp_u.delete();
        exp_c.delete();
        for (int k = 0; k < n; k++) begin
            if (k < sect) begin
                if (ovr < 0 || k < ovr) exp_u.push_back(d[k]);
            end else if (ovr < 0) begin
                exp_c.push_back(d[k]);
            end
        end
        do_start(1'b0, sect, ecc, 0);
        strobe(1'b0, 8'h55);
        strobe(1'b0, 8'h5A);
        strobe(1'b0, 8'hA1);
        for (int k = 0; k < n; k++) begin
            if (k == split_a || k == split_b) begin
                repeat (3) strobe(1'b1, 8'hA1);
                strobe(1'b0, 8'h3C);
                strobe(1'b0, 8'hA1);
            end
            user_ready = !(k == ovr);
            strobe(1'b0, d[k]);
            if (k == ovr) break;
        end
        user_ready = 1'b1;
        if (ovr < 0) strobe(1'b0, 8'h77);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "R6 watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ns, d0, e0;
        clear_sched();
        repeat (4) @(negedge clk);
        // R1: reset state
        check(!write_gate && !read_gate, "R1 gates at reset", int'({write_gate, read_gate}), 0);
        check(!done && !user_valid && !chk_valid, "R1 pulses at reset",
              int'({done, user_valid, chk_valid}), 0);
        check(!err_underrun && !err_overrun, "R1 errors at reset",
              int'({err_underrun, err_overrun}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2/R6/R9: plain write
        d0 = done_cnt;
        write_sector(6, 2, 3, -1, ns);
        check(done_cnt == d0 + 1, "R9 one done per write", done_cnt - d0, 1);
        check(exp_w.size() == 0, "R2 all bytes written", exp_w.size(), 0);
        check(ns == 3 + 6 + 2 + 2, "R6 strobe count", ns, 13);

        // R11: no preamble
        write_sector(4, 2, 0, -1, ns);
        check(exp_w.size() == 0, "R11 all bytes written", exp_w.size(), 0);
        check(ns == 0 + 4 + 2 + 2, "R6 strobe count no pad", ns, 8);

        // R4/R5: write split by wedges in data and in a preamble
        clear_sched();
        for (int i = 6; i <= 8; i++) sched[i] = 1'b1;
        for (int i = 15; i <= 16; i++) sched[i] = 1'b1;
        sched[18] = 1'b1;
        d0 = done_cnt;
        write_sector(10, 3, 2, -1, ns);
        check(done_cnt == d0 + 1, "R5 split write done", done_cnt - d0, 1);
        check(exp_w.size() == 0, "R5 split write complete", exp_w.size(), 0);
        check(seg_idx == 4, "R5 segment count", seg_idx, 4);

        // R4/R5: wedge inside the check bytes
        clear_sched();
        sched[9] = 1'b1;
        write_sector(5, 4, 1, -1, ns);
        check(exp_w.size() == 0, "R5 wedge in check bytes", exp_w.size(), 0);
        clear_sched();

        // R7: underrun
        d0 = done_cnt;
        e0 = eu_cnt;
        write_sector(6, 2, 1, 3, ns);
        check(eu_cnt == e0 + 1, "R7 underrun flagged", eu_cnt - e0, 1);
        check(done_cnt == d0, "R7 no done after underrun", done_cnt - d0, 0);
        check(!write_gate, "R7 gate low after underrun", int'(write_gate), 0);
        check(exp_w.size() == 0, "R7 bytes before underrun", exp_w.size(), 0);

        // R3: plain read
        d0 = done_cnt;
        read_sector(5, 2, -1, -1, -1);
        check(done_cnt == d0 + 1, "R9 one done per read", done_cnt - d0, 1);
        check(exp_u.size() == 0 && exp_c.size() == 0, "R3 read complete",
              exp_u.size() + exp_c.size(), 0);

        // R5: read split twice, once in user and once in check bytes
        d0 = done_cnt;
        read_sector(8, 3, 4, 9, -1);
        check(done_cnt == d0 + 1, "R5 split read done", done_cnt - d0, 1);
        check(exp_u.size() == 0 && exp_c.size() == 0, "R5 split read complete",
              exp_u.size() + exp_c.size(), 0);

        // R8: overrun
        d0 = done_cnt;
        e0 = eo_cnt;
        read_sector(6, 2, -1, -1, 3);
        repeat (2) @(negedge clk);
        check(eo_cnt == e0 + 1, "R8 overrun flagged", eo_cnt - e0, 1);
        check(done_cnt == d0, "R8 no done after overrun", done_cnt - d0, 0);
        check(!read_gate, "R8 gate low after overrun", int'(read_gate), 0);
        check(exp_u.size() == 0, "R8 bytes before overrun", exp_u.size(), 0);

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule